// File: doc/BRIEF.md
# Half-Cycle Shared-Port Register File

This block is a processor register file with one write port and two read ports. It is built from storage banks that each have only a single address port. In every clock cycle that one port is shared between a write and a read. While the clock is low, a clock-level selector puts the destination register number on the port, and the result is stored at the rising edge. While the clock is high, the same selector puts the source register number on the port, and the word that comes out is captured into output flops at the falling edge. Two identical banks receive every write, so each bank can serve its own read address. This gives two independent read ports.

The word width and the register count are parameters. The intended settings are 16 registers of 16 bits, 16 registers of 32 bits, and 32 registers of 32 bits. A small controller handles reset. It has two states. ST_CLEAR walks an index from 0 to the last register and writes zero through the shared port, one register per cycle. ST_RUN passes the user's write request to the banks.

The controller moves between its states as follows:
- A synchronous reset, taken at a rising edge, enters ST_CLEAR from either state.
- ST_CLEAR steps to the next register on each rising edge.
- ST_CLEAR moves to ST_RUN on the rising edge that clears the last register.
- ST_RUN stays in ST_RUN until the next reset.

The sequence of one cycle is as follows:
1. Drive the write and read requests in the low phase.
2. The write takes effect at the rising edge.
3. The read data is valid just after the falling edge that follows.

Top module: `halfcycle_regfile`

## Requirements
- R1: When wr_en is high at a rising edge in ST_RUN, wr_data is stored in register wr_addr of both banks, so that either read port can return it.
- R2: Port A returns the register named by rd_addr_a during the high phase. The word is captured at the falling edge that ends that phase and held on rd_data_a until the next falling edge.
- R3: Port B behaves like port A, using rd_addr_b and rd_data_b, and is independent of port A.
- R4: A register written at a rising edge and named as a source in the high phase that follows returns the new value at that falling edge, on both ports.
- R5: When wr_en is low at a rising edge, no register is modified, whatever wr_addr and wr_data hold. The read captures still take place at the next falling edge.
- R6: When both read addresses name the same register, rd_data_a and rd_data_b are equal.
- R7: A synchronous reset enters ST_CLEAR. The controller then spends REG_N rising edges writing zero to every register, one per edge, in index order. While the pass runs, both read outputs are zero and user writes are ignored. After the pass, every register reads zero.
- R8: Register 0 and register REG_N-1 are both addressable. All-ones and all-zero words are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Its level selects the shared address: write address while low, read address while high. |
| rst | input | 1 | Synchronous reset, active high, sampled at the rising edge. |
| wr_en | input | 1 | Write request for the next rising edge. |
| wr_addr | input | ADDR_W | Destination register number. |
| wr_data | input | DATA_W | Word to write. |
| rd_addr_a | input | ADDR_W | Source register number for port A. |
| rd_addr_b | input | ADDR_W | Source register number for port B. |
| rd_data_a | output | DATA_W | Port A word, captured at the falling edge. |
| rd_data_b | output | DATA_W | Port B word, captured at the falling edge. |

## Verification
The properties take the following for granted about the inputs:
- wr_en, wr_addr and wr_data are settled during the low phase and stay steady across the rising edge.
- The read addresses stay steady through the whole high phase and across the falling edge.
- Reset changes only while the clock is low.

The bench keeps within these limits by changing every input once per cycle, one nanosecond after a falling edge. It also samples the read outputs at that same instant, before it drives anything new.

// File: rtl/hcrf_pkg.sv
package hcrf_pkg;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } hcrf_state_e;

    localparam int unsigned HCRF_BANKS = 2;

endpackage

// File: rtl/hcrf_ctrl.sv
module hcrf_ctrl
    import hcrf_pkg::*;
#(
    parameter int unsigned REG_N  = 32,
    parameter int unsigned ADDR_W = $clog2(REG_N),
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_we,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_data,
    output logic              bank_we,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [DATA_W-1:0] bank_data,
    output logic              running
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(REG_N - 1);

    hcrf_state_e       state_q;
    logic [ADDR_W-1:0] idx_q;

    // State register: the clear pass and the normal run state.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_CLEAR: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_RUN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    state_q <= ST_RUN;
                end
                default: begin
                    state_q <= ST_CLEAR;
                end
            endcase
        end
    end

    // Output process: choose the source of the low-phase write.
    always_comb begin
        bank_we   = 1'b0;
        bank_addr = '0;
        bank_data = '0;
        running   = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                bank_we   = 1'b1;
                bank_addr = idx_q;
                bank_data = '0;
            end
            ST_RUN: begin
                bank_we   = usr_we;
                bank_addr = usr_addr;
                bank_data = usr_data;
                running   = 1'b1;
            end
            default: begin
                bank_we = 1'b0;
            end
        endcase
    end

    // R7
    clear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLEAR && idx_q != LAST_IDX)
            |=> (state_q == ST_CLEAR && idx_q == ADDR_W'($past(idx_q) + 1'b1)));

    // R7
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

endmodule

// File: rtl/hcrf_phase_mux.sv
module hcrf_phase_mux #(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] lo_sel,
    input  logic [ADDR_W-1:0] hi_sel,
    output logic [ADDR_W-1:0] port_addr
);

    // The clock level picks the address: destination while low,
    // source while high.
    always_comb begin
        if (clk) begin
            port_addr = hi_sel;
        end else begin
            port_addr = lo_sel;
        end
    end

endmodule

// File: rtl/hcrf_bank.sv
module hcrf_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_N  = 32,
    parameter int unsigned ADDR_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hold_zero,
    output logic [DATA_W-1:0] rd_q
);

    logic [DATA_W-1:0] mem [REG_N];
    logic [ADDR_W-1:0] wlat;
    logic [ADDR_W-1:0] rlat;

    // The address presented during the low phase is held through the
    // rising edge.
    always_latch begin
        if (!clk) begin
            wlat = port_addr;
        end
    end

    // The address presented during the high phase is held through the
    // falling edge.
    always_latch begin
        if (clk) begin
            rlat = port_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wlat] <= wr_data;
        end
    end

    always_ff @(negedge clk) begin
        if (rst || hold_zero) begin
            rd_q <= '0;
        end else begin
            rd_q <= mem[rlat];
        end
    end

    // R1
    wr_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wlat)] == $past(wr_data)));

endmodule

// File: rtl/halfcycle_regfile.sv
module halfcycle_regfile
    import hcrf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_N  = 32,
    parameter int unsigned ADDR_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);

    logic              bank_we;
    logic [ADDR_W-1:0] bank_addr;
    logic [DATA_W-1:0] bank_data;
    logic              running;

    logic [ADDR_W-1:0] src_sel  [HCRF_BANKS];
    logic [DATA_W-1:0] bank_out [HCRF_BANKS];

    assign src_sel[0] = rd_addr_a;
    assign src_sel[1] = rd_addr_b;

    hcrf_ctrl #(
        .REG_N  (REG_N),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .usr_we    (wr_en),
        .usr_addr  (wr_addr),
        .usr_data  (wr_data),
        .bank_we   (bank_we),
        .bank_addr (bank_addr),
        .bank_data (bank_data),
        .running   (running)
    );

    for (genvar g = 0; g < HCRF_BANKS; g++) begin : g_bank
        logic [ADDR_W-1:0] shared_addr;

        hcrf_phase_mux #(
            .ADDR_W (ADDR_W)
        ) mux_i (
            .clk       (clk),
            .lo_sel    (bank_addr),
            .hi_sel    (src_sel[g]),
            .port_addr (shared_addr)
        );

        hcrf_bank #(
            .DATA_W (DATA_W),
            .REG_N  (REG_N),
            .ADDR_W (ADDR_W)
        ) bank_i (
            .clk       (clk),
            .rst       (rst),
            .port_addr (shared_addr),
            .wr_en     (bank_we),
            .wr_data   (bank_data),
            .hold_zero (!running),
            .rd_q      (bank_out[g])
        );
    end

    assign rd_data_a = bank_out[0];
    assign rd_data_b = bank_out[1];

    // R6
    same_src_chk: assert property (@(negedge clk) disable iff (rst)
        (rd_addr_a == rd_addr_b) |=> (rd_data_a == rd_data_b));

    // R7
    clear_quiet_chk: assert property (@(negedge clk) disable iff (rst)
        (!running) |=> (rd_data_a == '0 && rd_data_b == '0));

endmodule

// File: tb/halfcycle_regfile_tb_top.sv
module halfcycle_regfile_tb_top;

    localparam int unsigned DW = 32;
    localparam int unsigned RN = 32;
    localparam int unsigned AW = $clog2(RN);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr_a = '0;
    logic [AW-1:0] rd_addr_b = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;

    logic [DW-1:0] model [RN];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    halfcycle_regfile #(.DATA_W(DW), .REG_N(RN)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives one cycle just after a falling edge, then samples the
    // captures of the next falling edge.
    task automatic cyc(input logic we, input int wa, input logic [DW-1:0] wd,
                       input int ra, input int rb, input string req);
        wr_en     = we;
        wr_addr   = AW'(wa);
        wr_data   = wd;
        rd_addr_a = AW'(ra);
        rd_addr_b = AW'(rb);
        if (we) model[wa] = wd;
        @(negedge clk);
        #1;
        check({req, " port A"}, rd_data_a, model[ra]);
        check({req, " port B"}, rd_data_b, model[rb]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R7 reset port A", rd_data_a, '0);
        check("R7 reset port B", rd_data_b, '0);
        rst = 1'b0;
        for (int i = 0; i < RN; i++) model[i] = '0;
        for (int i = 0; i < 6; i++) begin
            wr_en = 1'b1;
            wr_addr = AW'(3 + i);
            wr_data = 32'hDEAD_0000 + i;
            rd_addr_a = AW'(i);
            rd_addr_b = AW'(3 + i);
            @(negedge clk);
            #1;
            check("R7 quiet during clear A", rd_data_a, '0);
            check("R7 quiet during clear B", rd_data_b, '0);
        end
        wr_en = 1'b0;
        repeat (RN) @(negedge clk);
        #1;
        for (int i = 0; i < RN; i++) cyc(1'b0, 0, '0, i, RN - 1 - i, "R7 cleared");
    endtask

    task automatic t_basic();
        for (int i = 0; i < 8; i++) cyc(1'b1, i * 3 % RN, 32'h1111_0000 ^ (i * 32'h0101_0101), 0, 1, "R1 write");
        for (int i = 0; i < 8; i++) cyc(1'b0, 0, '0, i * 3 % RN, (i * 3 + 3) % RN, "R2 R3 read");
    endtask

    task automatic t_write_through();
        for (int i = 0; i < 10; i++) begin
            int r = (i * 7 + 2) % RN;
            cyc(1'b1, r, 32'hA5A5_0000 + i * 32'h13, r, r, "R4 same-cycle");
        end
        cyc(1'b1, 5, 32'h0BAD_F00D, 5, 6, "R4 port A only");
        cyc(1'b1, 6, 32'h600D_CAFE, 5, 6, "R4 port B only");
    endtask

    task automatic t_no_write();
        cyc(1'b1, 9, 32'h0000_0999, 9, 9, "R5 setup");
        cyc(1'b0, 9, 32'hFFFF_0000, 9, 10, "R5 idle same cycle");
        cyc(1'b0, 10, 32'h1234_5678, 9, 10, "R5 idle next");
        cyc(1'b0, 0, '0, 10, 9, "R5 after idle");
    endtask

    task automatic t_same_src();
        for (int i = 0; i < RN; i += 5) cyc(1'b0, 0, '0, i, i, "R6 same source");
    endtask

    task automatic t_bounds();
        cyc(1'b1, RN - 1, '1, RN - 1, 0, "R8 top all-ones");
        cyc(1'b1, 0, '1, 0, RN - 1, "R8 zero all-ones");
        cyc(1'b1, RN - 1, '0, RN - 1, 0, "R8 top all-zero");
        cyc(1'b0, 0, '0, 0, RN - 1, "R8 readback");
    endtask

    task automatic t_sweep();
        for (int i = 0; i < RN; i++) cyc(1'b1, i, (i + 1) * 32'h9E37_79B1, (i + RN - 1) % RN, i, "R1 R4 fill");
        for (int i = 0; i < RN; i++) cyc(1'b0, 0, '0, i, (i + 11) % RN, "R2 R3 sweep");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < RN; i++) model[i] = '0;
        #1;
        do_reset();
        t_basic();
        t_write_through();
        t_no_write();
        t_same_src();
        t_bounds();
        t_sweep();
        do_reset();
        t_write_through();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule